// File: doc/BRIEF.md
# Indexed Load/Store Address Generator

This block works out the memory address for one load or store and the new value of its base register. The request carries a base register value and the number of that register. It also carries an offset, which is either a zero-extended immediate byte count or the contents of an index register. The offset is added to or subtracted from the base. In pre-indexed mode the access goes to the adjusted address, and the base takes that address only if writeback is requested. In post-indexed mode the access goes to the unchanged base, and the base always takes the adjusted value. All arithmetic wraps modulo 2^XLEN and raises no flag.

The program-counter register (number 15 by default) has special handling. As a base it reads as the instruction address plus 8. As the source of a halfword store it supplies the instruction address plus 12. Two combinations are illegal: the program counter as base together with any effective writeback, and the program counter as the index register of a register offset. Either one raises an illegal flag and suppresses the writeback enable. The store word is also given replicated across both halfword lanes of the data bus.

Requests enter on a valid/ready port, and results leave one cycle later on a valid/ready port. A single register stage sits between them. The stage takes a new request whenever it is empty or its result is being taken in the same cycle. While the consumer holds ready low, the result stays frozen and the input is back-pressured.

Top module: `agu_top`

## Requirements
- R1: In pre-indexed mode (pre_idx=1), mem_addr equals base ± offset, new_base equals mem_addr, and wb_en equals wb_req when the request is legal.
- R2: In post-indexed mode (pre_idx=0), mem_addr equals the unmodified base, new_base equals base ± offset, and wb_en is 1 whether or not wb_req is set, when the request is legal. For example, base B with immediate 223 and up=0 accesses B and writes back B−223.
- R3: The offset is the immediate zero-extended when use_imm=1, and index_val when use_imm=0. up=1 adds and up=0 subtracts. Results wrap modulo 2^XLEN.
- R4: When base_idx is 15, the base reads as insn_addr+8 and base_val is ignored.
- R5: illegal is 1 when base_idx is 15 and writeback is in effect (pre-indexed with wb_req=1, or any post-indexed request).
- R6: illegal is 1 when use_imm=0 and index_idx is 15. index_idx has no effect when use_imm=1.
- R7: When illegal is 1, wb_en is 0. mem_addr and new_base are still computed as usual.
- R8: store_word is insn_addr+12 when src_idx is 15, and src_val otherwise. store_bus carries the low half of store_word in both its upper and lower halves.
- R9: A request is taken on a clock edge where in_valid and in_ready are both 1. Its result appears with out_valid=1 after that edge. in_ready is 1 when the output is empty or out_ready is 1.
- R10: While out_valid=1 and out_ready=0, all result outputs and out_valid hold their values on the next cycle.
- R11: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| base_val | input | XLEN | Base register contents |
| base_idx | input | IDX_W | Base register number |
| index_val | input | XLEN | Index register contents |
| index_idx | input | IDX_W | Index register number |
| imm | input | IMM_W | Immediate byte offset |
| use_imm | input | 1 | 1: immediate offset, 0: index register |
| up | input | 1 | 1: add offset, 0: subtract |
| pre_idx | input | 1 | 1: pre-indexed, 0: post-indexed |
| wb_req | input | 1 | Writeback request (pre-indexed only) |
| insn_addr | input | XLEN | Address of the current instruction |
| src_idx | input | IDX_W | Store source register number |
| src_val | input | XLEN | Store source register contents |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result when high |
| mem_addr | output | XLEN | Access address |
| new_base | output | XLEN | Updated base value |
| wb_en | output | 1 | Write new_base back to the base register |
| illegal | output | 1 | Illegal register combination |
| store_word | output | XLEN | Value to store |
| store_bus | output | XLEN | Low half of store_word on both halves |

## Verification
The bench builds the block with its defaults: XLEN=32, an 8-bit immediate and register 15 as the program counter. The 8-bit immediate is wide enough for the 223-byte post-indexed example. The 32-bit width puts the wrap at 2^32 within reach with bases near all-ones or zero. With a 4-bit register number, random stimulus hits register 15 in each of the base, index and source roles about one time in sixteen. Randomly withheld out_ready exercises back-pressure and the held-output rule.

// File: rtl/agu_pkg.sv
package agu_pkg;
  // addressing mode
  typedef enum logic {
    MODE_POST = 1'b0,
    MODE_PRE  = 1'b1
  } idx_mode_e;

  // offset source
  typedef enum logic {
    OFS_REG = 1'b0,
    OFS_IMM = 1'b1
  } ofs_src_e;
endpackage

// File: rtl/agu_operand_sel.sv
module agu_operand_sel #(
  parameter int XLEN         = 32,
  parameter int IDX_W        = 4,
  parameter int IMM_W        = 8,
  parameter int PC_IDX       = 15,
  parameter int BASE_PC_OFS  = 8,
  parameter int SRC_PC_OFS   = 12
) (
  input  logic [XLEN-1:0]  base_val,
  input  logic [IDX_W-1:0] base_idx,
  input  logic [XLEN-1:0]  index_val,
  input  logic [IMM_W-1:0] imm,
  input  agu_pkg::ofs_src_e ofs_src,
  input  logic [XLEN-1:0]  insn_addr,
  input  logic [IDX_W-1:0] src_idx,
  input  logic [XLEN-1:0]  src_val,
  output logic [XLEN-1:0]  base_eff,
  output logic [XLEN-1:0]  offset,
  output logic [XLEN-1:0]  store_word
);
  localparam logic [IDX_W-1:0] PC_NUM   = IDX_W'(PC_IDX);
  localparam logic [XLEN-1:0]  BASE_ADJ = XLEN'(BASE_PC_OFS);
  localparam logic [XLEN-1:0]  SRC_ADJ  = XLEN'(SRC_PC_OFS);
  localparam int               PAD_W    = XLEN - IMM_W;

  logic base_is_pc;
  logic src_is_pc;

  assign base_is_pc = (base_idx == PC_NUM);
  assign src_is_pc  = (src_idx == PC_NUM);

  always_comb begin
    if (base_is_pc) base_eff = insn_addr + BASE_ADJ;
    else            base_eff = base_val;
  end

  always_comb begin
    if (ofs_src == agu_pkg::OFS_IMM) offset = {{PAD_W{1'b0}}, imm};
    else                             offset = index_val;
  end

  always_comb begin
    if (src_is_pc) store_word = insn_addr + SRC_ADJ;
    else           store_word = src_val;
  end
endmodule

// File: rtl/agu_addsub.sv
module agu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         up,
  output logic [W-1:0] y
);
  always_comb begin
    if (up) y = a + b;
    else    y = a - b;
  end
endmodule

// File: rtl/agu_legality.sv
module agu_legality #(
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15
) (
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [IDX_W-1:0]  index_idx,
  input  agu_pkg::ofs_src_e ofs_src,
  input  logic              wb_want,
  output logic              illegal
);
  localparam logic [IDX_W-1:0] PC_NUM = IDX_W'(PC_IDX);

  logic bad_base;
  logic bad_index;

  assign bad_base  = (base_idx == PC_NUM) && wb_want;
  assign bad_index = (ofs_src == agu_pkg::OFS_REG) && (index_idx == PC_NUM);
  assign illegal   = bad_base | bad_index;
endmodule

// File: rtl/agu_out_reg.sv
module agu_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign s_ready = !vld_q || m_ready;
  assign m_valid = vld_q;
  assign m_data  = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else if (s_ready) begin
      vld_q <= s_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
    end else if (s_ready && s_valid) begin
      dat_q <= s_data;
    end
  end
endmodule

// File: rtl/agu_top.sv
module agu_top #(
  parameter int XLEN        = 32,
  parameter int IDX_W       = 4,
  parameter int IMM_W       = 8,
  parameter int PC_IDX      = 15,
  parameter int BASE_PC_OFS = 8,
  parameter int SRC_PC_OFS  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [XLEN-1:0]  base_val,
  input  logic [IDX_W-1:0] base_idx,
  input  logic [XLEN-1:0]  index_val,
  input  logic [IDX_W-1:0] index_idx,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  input  logic             up,
  input  logic             pre_idx,
  input  logic             wb_req,
  input  logic [XLEN-1:0]  insn_addr,
  input  logic [IDX_W-1:0] src_idx,
  input  logic [XLEN-1:0]  src_val,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  new_base,
  output logic             wb_en,
  output logic             illegal,
  output logic [XLEN-1:0]  store_word,
  output logic [XLEN-1:0]  store_bus
);
  localparam int HALF_W = XLEN / 2;
  localparam int LANES  = XLEN / HALF_W;
  localparam int PAY_W  = 3 * XLEN + 2;

  agu_pkg::idx_mode_e mode;
  agu_pkg::ofs_src_e  ofs_src;

  assign mode    = agu_pkg::idx_mode_e'(pre_idx);
  assign ofs_src = agu_pkg::ofs_src_e'(use_imm);

  logic [XLEN-1:0] base_eff;
  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] st_word_c;
  logic [XLEN-1:0] adjusted;
  logic [XLEN-1:0] addr_c;
  logic            wb_want;
  logic            bad_c;
  logic            wb_c;

  agu_operand_sel #(
    .XLEN(XLEN), .IDX_W(IDX_W), .IMM_W(IMM_W), .PC_IDX(PC_IDX),
    .BASE_PC_OFS(BASE_PC_OFS), .SRC_PC_OFS(SRC_PC_OFS)
  ) u_sel (
    .base_val  (base_val),
    .base_idx  (base_idx),
    .index_val (index_val),
    .imm       (imm),
    .ofs_src   (ofs_src),
    .insn_addr (insn_addr),
    .src_idx   (src_idx),
    .src_val   (src_val),
    .base_eff  (base_eff),
    .offset    (offset),
    .store_word(st_word_c)
  );

  agu_addsub #(.W(XLEN)) u_add (
    .a (base_eff),
    .b (offset),
    .up(up),
    .y (adjusted)
  );

  always_comb begin
    if (mode == agu_pkg::MODE_PRE) begin
      addr_c  = adjusted;
      wb_want = wb_req;
    end else begin
      addr_c  = base_eff;
      wb_want = 1'b1;
    end
  end

  agu_legality #(.IDX_W(IDX_W), .PC_IDX(PC_IDX)) u_leg (
    .base_idx (base_idx),
    .index_idx(index_idx),
    .ofs_src  (ofs_src),
    .wb_want  (wb_want),
    .illegal  (bad_c)
  );

  assign wb_c = wb_want & ~bad_c;

  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_out;

  assign pay_in = {addr_c, adjusted, wb_c, bad_c, st_word_c};

  agu_out_reg #(.W(PAY_W)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_valid(in_valid),
    .s_ready(in_ready),
    .s_data (pay_in),
    .m_valid(out_valid),
    .m_ready(out_ready),
    .m_data (pay_out)
  );

  assign {mem_addr, new_base, wb_en, illegal, store_word} = pay_out;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign store_bus[g*HALF_W +: HALF_W] = store_word[HALF_W-1:0];
  end
endmodule

// File: rtl/agu_top_chk.sv
module agu_top_chk #(
  parameter int XLEN        = 32,
  parameter int IDX_W       = 4,
  parameter int PC_IDX      = 15,
  parameter int BASE_PC_OFS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IDX_W-1:0] base_idx,
  input logic [IDX_W-1:0] index_idx,
  input logic             use_imm,
  input logic             pre_idx,
  input logic [XLEN-1:0]  insn_addr,
  input logic             out_valid,
  input logic             out_ready,
  input logic [XLEN-1:0]  mem_addr,
  input logic [XLEN-1:0]  new_base,
  input logic             wb_en,
  input logic             illegal,
  input logic [XLEN-1:0]  store_word
);
  localparam logic [IDX_W-1:0] PC_NUM = IDX_W'(PC_IDX);

  // R9
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(mem_addr) && $stable(new_base)
      && $stable(wb_en) && $stable(illegal) && $stable(store_word)));

  // R7
  illegal_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> !wb_en);

  // R6
  pc_index_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !use_imm && index_idx == PC_NUM) |=> illegal);

  // R2
  post_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !pre_idx && base_idx != PC_NUM
     && !(!use_imm && index_idx == PC_NUM)) |=> wb_en);

  // R4
  pc_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !pre_idx && base_idx == PC_NUM)
      |=> (mem_addr == $past(insn_addr) + XLEN'(BASE_PC_OFS)));
endmodule

bind agu_top agu_top_chk #(
  .XLEN(XLEN), .IDX_W(IDX_W), .PC_IDX(PC_IDX), .BASE_PC_OFS(BASE_PC_OFS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .base_idx  (base_idx),
  .index_idx (index_idx),
  .use_imm   (use_imm),
  .pre_idx   (pre_idx),
  .insn_addr (insn_addr),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .mem_addr  (mem_addr),
  .new_base  (new_base),
  .wb_en     (wb_en),
  .illegal   (illegal),
  .store_word(store_word)
);

// File: tb/sim_agu_top.sv
`timescale 1ns/1ps
module sim_agu_top;
  localparam int XLEN = 32;
  localparam int IDX_W = 4;
  localparam int IMM_W = 8;
  localparam int QD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             in_valid = 1'b0, in_ready;
  logic [XLEN-1:0]  base_val = '0, index_val = '0, insn_addr = '0, src_val = '0;
  logic [IDX_W-1:0] base_idx = '0, index_idx = '0, src_idx = '0;
  logic [IMM_W-1:0] imm = '0;
  logic             use_imm = 1'b0, up = 1'b0, pre_idx = 1'b0, wb_req = 1'b0;
  logic             out_valid, out_ready = 1'b0;
  logic [XLEN-1:0]  mem_addr, new_base, store_word, store_bus;
  logic             wb_en, illegal;

  agu_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .base_val(base_val), .base_idx(base_idx), .index_val(index_val),
    .index_idx(index_idx), .imm(imm), .use_imm(use_imm), .up(up),
    .pre_idx(pre_idx), .wb_req(wb_req), .insn_addr(insn_addr),
    .src_idx(src_idx), .src_val(src_val), .out_valid(out_valid),
    .out_ready(out_ready), .mem_addr(mem_addr), .new_base(new_base),
    .wb_en(wb_en), .illegal(illegal), .store_word(store_word),
    .store_bus(store_bus)
  );

  typedef struct packed {
    logic [XLEN-1:0] addr;
    logic [XLEN-1:0] nb;
    logic            wb;
    logic            bad;
    logic [XLEN-1:0] sw;
    logic [XLEN-1:0] sb;
  } exp_t;

  int   n_chk = 0;
  int   n_bad = 0;
  exp_t q_exp [QD];
  string q_tag [QD];
  int   wr = 0, rd = 0;
  string cur_tag = "R1 R2 R3";

  function automatic exp_t model();
    exp_t e;
    logic [XLEN-1:0] b, o, s;
    logic want;
    b = (base_idx == 4'd15) ? insn_addr + 32'd8 : base_val;              // R4
    o = use_imm ? {24'd0, imm} : index_val;                               // R3
    s = up ? b + o : b - o;
    e.addr = pre_idx ? s : b;                                             // R1 R2
    e.nb   = s;
    want   = pre_idx ? wb_req : 1'b1;
    e.bad  = (base_idx == 4'd15 && want) || (!use_imm && index_idx == 4'd15); // R5 R6
    e.wb   = want && !e.bad;                                              // R7
    e.sw   = (src_idx == 4'd15) ? insn_addr + 32'd12 : src_val;           // R8
    e.sb   = {e.sw[15:0], e.sw[15:0]};
    return e;
  endfunction

  task automatic check_out();
    exp_t e, a;
    e = q_exp[rd];
    a = '{mem_addr, new_base, wb_en, illegal, store_word, store_bus};
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s: got addr=%h nb=%h wb=%b bad=%b sw=%h sb=%h exp addr=%h nb=%h wb=%b bad=%b sw=%h sb=%h",
        q_tag[rd], a.addr, a.nb, a.wb, a.bad, a.sw, a.sb,
        e.addr, e.nb, e.wb, e.bad, e.sw, e.sb);
    end
    rd = (rd + 1) % QD;
  endtask

  logic            hold_pend = 1'b0;
  exp_t            hold_val;

  // one cycle: inputs already set before call; evaluate handshakes of next edge
  task automatic settle_and_track(output logic accepted);
    #1;
    if (hold_pend) begin
      n_chk++;
      if (!out_valid || '{mem_addr, new_base, wb_en, illegal, store_word, store_bus} !== hold_val) begin
        n_bad++;
        $display("FAIL R10: got valid=%b addr=%h exp valid=1 addr=%h", out_valid, mem_addr, hold_val.addr);
      end
    end
    hold_pend = out_valid && !out_ready;
    if (hold_pend) hold_val = '{mem_addr, new_base, wb_en, illegal, store_word, store_bus};
    if (out_valid && out_ready) check_out();
    accepted = in_valid && in_ready;
    if (accepted) begin
      q_exp[wr] = model();
      q_tag[wr] = cur_tag;
      wr = (wr + 1) % QD;
    end
  endtask

  task automatic send(input string tag, input logic [XLEN-1:0] bv, input logic [3:0] bi,
                      input logic [XLEN-1:0] iv, input logic [3:0] ii, input logic [7:0] im,
                      input logic ui, input logic u, input logic pr, input logic w,
                      input logic [XLEN-1:0] pc, input logic [3:0] si, input logic [XLEN-1:0] sv);
    logic acc;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      cur_tag = tag;
      base_val = bv; base_idx = bi; index_val = iv; index_idx = ii; imm = im;
      use_imm = ui; up = u; pre_idx = pr; wb_req = w; insn_addr = pc;
      src_idx = si; src_val = sv; in_valid = 1'b1; out_ready = 1'b1;
      settle_and_track(acc);
    end
  endtask

  task automatic drain();
    logic acc;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b1;
      settle_and_track(acc);
    end
  endtask

  bit done = 1'b0;
  initial begin : watchdog
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic acc;
    void'($urandom(32'h1d5a));
    repeat (3) @(negedge clk);
    // R11 reset state
    n_chk++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R11: got out_valid=%b in_ready=%b exp 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;

    // R2: post-index immediate subtract 223
    send("R2 post imm -223", 32'h0000_1000, 4'd2, 32'h0, 4'd3, 8'd223, 1, 0, 0, 0, 32'h100, 4'd1, 32'h0);
    // R2: post-index ignores wb_req (set)
    send("R2 post wb_req=1", 32'h0000_2000, 4'd4, 32'h30, 4'd5, 8'd0, 0, 1, 0, 1, 32'h100, 4'd1, 32'h0);
    // R1: pre-index no writeback
    send("R1 pre no wb", 32'h0000_0040, 4'd4, 32'h0, 4'd5, 8'd14, 1, 1, 1, 0, 32'h100, 4'd3, 32'h1234_5678);
    // R1: pre-index register subtract with writeback
    send("R1 pre reg wb", 32'h0000_0100, 4'd2, 32'h10, 4'd3, 8'd0, 0, 0, 1, 1, 32'h100, 4'd1, 32'h0);
    // R3: wrap past all-ones
    send("R3 wrap add", 32'hFFFF_FFFF, 4'd1, 32'h0, 4'd0, 8'd2, 1, 1, 1, 1, 32'h0, 4'd0, 32'h0);
    send("R3 wrap sub", 32'h0000_0001, 4'd1, 32'h3, 4'd0, 8'd0, 0, 0, 0, 0, 32'h0, 4'd0, 32'h0);
    // R4: base PC, pre-index no writeback is legal
    send("R4 pc base", 32'hDEAD_BEEF, 4'd15, 32'h0, 4'd0, 8'd4, 1, 1, 1, 0, 32'h0000_8000, 4'd0, 32'h0);
    // R5 R7: base PC with writeback
    send("R5 R7 pc base wb", 32'h0, 4'd15, 32'h0, 4'd0, 8'd4, 1, 1, 1, 1, 32'h0000_8000, 4'd0, 32'h0);
    send("R5 R7 pc base post", 32'h0, 4'd15, 32'h0, 4'd0, 8'd4, 1, 0, 0, 0, 32'h0000_8000, 4'd0, 32'h0);
    // R6: PC as index register
    send("R6 pc index", 32'h500, 4'd1, 32'h7, 4'd15, 8'd0, 0, 1, 1, 1, 32'h0, 4'd0, 32'h0);
    // R6: index 15 ignored with immediate
    send("R6 imm ignores index", 32'h500, 4'd1, 32'h7, 4'd15, 8'd9, 1, 1, 1, 1, 32'h0, 4'd0, 32'h0);
    // R8: store source PC
    send("R8 pc store", 32'h0, 4'd1, 32'h0, 4'd0, 8'd0, 1, 1, 1, 0, 32'h0000_4000, 4'd15, 32'hFFFF_FFFF);
    send("R8 store lanes", 32'h0, 4'd1, 32'h0, 4'd0, 8'd0, 1, 1, 1, 0, 32'h0, 4'd6, 32'hABCD_9876);
    drain();

    // R9 R10: random stimulus with back-pressure
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cur_tag = "R1 R2 R3 R9 random";
      base_val = $urandom; index_val = $urandom; insn_addr = $urandom; src_val = $urandom;
      base_idx = 4'($urandom); index_idx = 4'($urandom); src_idx = 4'($urandom);
      imm = 8'($urandom); use_imm = 1'($urandom); up = 1'($urandom);
      pre_idx = 1'($urandom); wb_req = 1'($urandom);
      in_valid = ($urandom % 4) != 0;
      out_ready = ($urandom % 3) != 0;
      settle_and_track(acc);
    end
    drain();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule